// File: doc/BRIEF.md
# SMT Fetch Thread Selector

This block decides, once per clock, which of four hardware threads may fetch instructions in the next cycle and how many instructions each of them may fetch. It sits beside the fetch unit of a simultaneous multithreading core. It keeps three saturating occupancy counters for every thread, and pipeline event strobes move them up and down:

- instructions in the front-end stages (decode, rename and the issue queues),
- branches that have not yet resolved,
- data-cache misses that are still outstanding.

A policy input picks the ranking metric. Rotation ranks every thread equally. The three count policies put the thread with the fewest of the chosen item first. The queue-position policy puts the thread whose oldest instruction is nearest the head of either issue queue last.

Ties are broken by a rotating pointer. A split input chooses one of three arrangements: one thread fetching eight, two threads fetching four each, or two threads fetching eight each. A per-thread enable removes stalled or idle threads from the contest. Grants are registered, so a decision always reflects the counters and inputs sampled at the previous clock edge.

Top module: `fetch_thread_sel`

## Requirements
- R1: After a synchronous active-low reset, `grant_o` and `grant_cnt_o` are all zero, every counter is zero and the rotation pointer points at thread 0.
- R2: Grants are registered. The outputs after edge k depend only on the counters, policy, split, enables and queue positions as they stood just before edge k.
- R3: Each thread has three counters: instructions (`inst_in_i` up, `inst_out_i` down), branches (`br_in_i` up, `br_res_i` down) and misses (`miss_start_i` up, `miss_done_i` down). Up and down in the same cycle leave a counter unchanged. A counter holds at 2^CNT_W-1 (15 by default) instead of wrapping and holds at 0 instead of going negative.
- R4: With `policy_i` set to 0 (rotation), or to any code from 5 to 7, all threads rank equally and are chosen in pointer order.
- R5: In every cycle that grants at least one thread, the pointer moves to the thread after the last one granted (the second if there are two), modulo 4. It is unchanged in cycles with no grant.
- R6: With `policy_i` set to 1, the thread with the lowest instruction counter ranks first.
- R7: With `policy_i` set to 2, the thread with the lowest branch counter ranks first.
- R8: With `policy_i` set to 3, the thread with the lowest miss counter ranks first.
- R9: With `policy_i` set to 4, each thread is keyed by the smaller of its two 5-bit queue positions (0 = head), and a larger key ranks first.
- R10: `split_i` sets the grant shape:
  - 1: the two best threads receive 4 each.
  - 2: the two best threads receive 8 each.
  - 0 or 3: only the best thread is granted, and it receives 8.
  
  Thread t's count sits at `grant_cnt_o[4t+3:4t]`, and it is nonzero exactly when `grant_o[t]` is set.
- R11: A thread whose `thread_en_i` bit is 0 is never granted. When fewer threads are enabled than the split asks for, only the enabled ones are granted.
- R12: Threads with equal metrics are ordered by their distance from the pointer, counting upward with wrap-around, and the nearest ranks first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy_i | input | 3 | Ranking policy code |
| split_i | input | 2 | Grant shape code |
| thread_en_i | input | 4 | Per-thread eligibility |
| inst_in_i | input | 4 | Instruction entered front-end stages, per thread |
| inst_out_i | input | 4 | Instruction left front-end stages, per thread |
| br_in_i | input | 4 | Unresolved branch entered, per thread |
| br_res_i | input | 4 | Branch resolved, per thread |
| miss_start_i | input | 4 | Data-cache miss started, per thread |
| miss_done_i | input | 4 | Data-cache miss completed, per thread |
| iq_pos_i | input | 20 | Integer queue position of each thread's oldest entry, 5 bits per thread |
| fq_pos_i | input | 20 | FP queue position of each thread's oldest entry, 5 bits per thread |
| grant_o | output | 4 | Fetch grant per thread |
| grant_cnt_o | output | 16 | Fetch count per thread, 4 bits each |

## Verification
The corner that is hardest to reach from the ports is a counter pinned at its ceiling or its floor while other threads sit near the same value. Only then does saturation change the ranking that can be seen at the outputs. The random stimulus alternates long windows in which increments dominate with windows in which decrements dominate, so that every counter repeatedly reaches both limits. Directed runs also pump one thread past 15 and another past zero, then order them under the count policy. Tie-breaking is exercised the same way: the run starts with all counters equal and enables are thinned at random, so the pointer keeps moving across gaps.

// File: rtl/fts_pkg.sv
// Package: shared policy and split codes for the fetch thread selector.
// Assumes: codes are driven as plain vectors at the top and cast here.
package fts_pkg;

    typedef enum logic [2:0] {
        POL_ROTATE = 3'd0,
        POL_INSTR  = 3'd1,
        POL_BRANCH = 3'd2,
        POL_MISS   = 3'd3,
        POL_QPOS   = 3'd4
    } policy_e;

    typedef enum logic [1:0] {
        SPLIT_ONE_FULL = 2'd0,
        SPLIT_TWO_HALF = 2'd1,
        SPLIT_TWO_FULL = 2'd2
    } split_e;

endpackage

// File: rtl/fts_sat_counter.sv
// Module: fts_sat_counter
// Up/down occupancy counter that saturates at both ends.
// Assumes: at most one up and one down event per cycle.
module fts_sat_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_i,
    input  logic         dn_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CMAX = {W{1'b1}};

    // Apply the net change, clamped to the range 0..CMAX.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (up_i && !dn_i && cnt_o != CMAX)
            cnt_o <= cnt_o + 1'b1;
        else if (dn_i && !up_i && cnt_o != '0)
            cnt_o <= cnt_o - 1'b1;
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CMAX && up_i && !dn_i) |=> cnt_o == CMAX);
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == '0 && dn_i && !up_i) |=> cnt_o == '0);
    assert_net_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_i && dn_i) |=> $stable(cnt_o));
endmodule

// File: rtl/fts_rank.sv
// Module: fts_rank
// Combinational picker: finds the best and the second-best eligible thread
// by the key {metric, distance from pointer}, with the smallest key first.
// Assumes: NT == 2**IW, so the distance wraps naturally.
module fts_rank #(
    parameter int NT = 4,
    parameter int MW = 5,
    parameter int IW = 2
) (
    input  logic [NT*MW-1:0] metric_i,
    input  logic [NT-1:0]    elig_i,
    input  logic [IW-1:0]    ptr_i,
    input  logic             two_i,
    output logic             first_vld_o,
    output logic [IW-1:0]    first_idx_o,
    output logic             second_vld_o,
    output logic [IW-1:0]    second_idx_o
);
    localparam int KW = MW + IW;

    logic [KW-1:0] key [NT];
    logic [KW-1:0] best1;
    logic [KW-1:0] best2;

    for (genvar g = 0; g < NT; g++) begin : g_key
        assign key[g] = {metric_i[g*MW +: MW], IW'(g) - ptr_i};
    end

    // Smallest key among the eligible threads.
    always_comb begin
        first_vld_o = 1'b0;
        first_idx_o = '0;
        best1       = '1;
        for (int i = 0; i < NT; i++) begin
            if (elig_i[i] && (!first_vld_o || key[i] < best1)) begin
                first_vld_o = 1'b1;
                first_idx_o = IW'(i);
                best1       = key[i];
            end
        end
    end

    // Next smallest key, excluding the first pick; used only in two-thread shapes.
    always_comb begin
        second_vld_o = 1'b0;
        second_idx_o = '0;
        best2        = '1;
        for (int i = 0; i < NT; i++) begin
            if (two_i && first_vld_o && elig_i[i] && IW'(i) != first_idx_o &&
                (!second_vld_o || key[i] < best2)) begin
                second_vld_o = 1'b1;
                second_idx_o = IW'(i);
                best2        = key[i];
            end
        end
    end
endmodule

// File: rtl/fetch_thread_sel.sv
// Module: fetch_thread_sel (top)
// Per-cycle fetch arbiter for an SMT front end. It keeps per-thread occupancy
// counters, forms a ranking metric from the selected policy, picks one or
// two threads and registers the grants and fetch counts.
// Assumes: NT is a power of two; event strobes are single-cycle pulses.
module fetch_thread_sel #(
    parameter int NT      = 4,
    parameter int CNT_W   = 4,
    parameter int QP_W    = 5,
    parameter int FETCH_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2:0]                    policy_i,
    input  logic [1:0]                    split_i,
    input  logic [NT-1:0]                 thread_en_i,
    input  logic [NT-1:0]                 inst_in_i,
    input  logic [NT-1:0]                 inst_out_i,
    input  logic [NT-1:0]                 br_in_i,
    input  logic [NT-1:0]                 br_res_i,
    input  logic [NT-1:0]                 miss_start_i,
    input  logic [NT-1:0]                 miss_done_i,
    input  logic [NT*QP_W-1:0]            iq_pos_i,
    input  logic [NT*QP_W-1:0]            fq_pos_i,
    output logic [NT-1:0]                 grant_o,
    output logic [NT*$clog2(FETCH_W+1)-1:0] grant_cnt_o
);
    import fts_pkg::*;

    localparam int IW  = $clog2(NT);
    localparam int MW  = (CNT_W > QP_W) ? CNT_W : QP_W;
    localparam int GCW = $clog2(FETCH_W + 1);
    localparam logic [QP_W-1:0] QMAX = {QP_W{1'b1}};

    logic [CNT_W-1:0]   inst_cnt [NT];
    logic [CNT_W-1:0]   br_cnt   [NT];
    logic [CNT_W-1:0]   miss_cnt [NT];
    logic [NT*MW-1:0]   metric;
    logic [IW-1:0]      ptr_q, ptr_nxt, last_idx;
    logic               two, f_vld, s_vld;
    logic [IW-1:0]      f_idx, s_idx;
    logic [GCW-1:0]     amt;
    logic [NT-1:0]      grant_nxt;
    logic [NT*GCW-1:0]  gcnt_nxt;

    policy_e pol;
    split_e  spl;
    assign pol = policy_e'(policy_i);
    assign spl = split_e'(split_i);

    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic [QP_W-1:0] qmin;

        fts_sat_counter #(.W(CNT_W)) u_inst (
            .clk(clk), .rst_n(rst_n), .up_i(inst_in_i[t]), .dn_i(inst_out_i[t]),
            .cnt_o(inst_cnt[t]));
        fts_sat_counter #(.W(CNT_W)) u_br (
            .clk(clk), .rst_n(rst_n), .up_i(br_in_i[t]), .dn_i(br_res_i[t]),
            .cnt_o(br_cnt[t]));
        fts_sat_counter #(.W(CNT_W)) u_miss (
            .clk(clk), .rst_n(rst_n), .up_i(miss_start_i[t]), .dn_i(miss_done_i[t]),
            .cnt_o(miss_cnt[t]));

        // Nearest-to-head position over both issue queues.
        assign qmin = (iq_pos_i[t*QP_W +: QP_W] < fq_pos_i[t*QP_W +: QP_W]) ?
                      iq_pos_i[t*QP_W +: QP_W] : fq_pos_i[t*QP_W +: QP_W];

        // Ranking metric for this thread under the active policy; lower is better.
        always_comb begin
            case (pol)
                POL_INSTR:  metric[t*MW +: MW] = MW'(inst_cnt[t]);
                POL_BRANCH: metric[t*MW +: MW] = MW'(br_cnt[t]);
                POL_MISS:   metric[t*MW +: MW] = MW'(miss_cnt[t]);
                POL_QPOS:   metric[t*MW +: MW] = MW'(QMAX - qmin);
                default:    metric[t*MW +: MW] = '0;
            endcase
        end
    end

    assign two = (spl == SPLIT_TWO_HALF) || (spl == SPLIT_TWO_FULL);
    assign amt = (spl == SPLIT_TWO_HALF) ? GCW'(FETCH_W / 2) : GCW'(FETCH_W);

    fts_rank #(.NT(NT), .MW(MW), .IW(IW)) u_rank (
        .metric_i(metric), .elig_i(thread_en_i), .ptr_i(ptr_q), .two_i(two),
        .first_vld_o(f_vld), .first_idx_o(f_idx),
        .second_vld_o(s_vld), .second_idx_o(s_idx));

    // Turn the picks into a grant vector, the per-thread counts and the next pointer.
    always_comb begin
        grant_nxt = '0;
        if (f_vld) grant_nxt[f_idx] = 1'b1;
        if (s_vld) grant_nxt[s_idx] = 1'b1;
        for (int t = 0; t < NT; t++)
            gcnt_nxt[t*GCW +: GCW] = grant_nxt[t] ? amt : '0;
        last_idx = s_vld ? s_idx : f_idx;
        ptr_nxt  = (last_idx == IW'(NT - 1)) ? '0 : last_idx + 1'b1;
    end

    // Register the grants; the pointer moves only when someone was granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_o     <= '0;
            grant_cnt_o <= '0;
            ptr_q       <= '0;
        end else begin
            grant_o     <= grant_nxt;
            grant_cnt_o <= gcnt_nxt;
            if (f_vld) ptr_q <= ptr_nxt;
        end
    end

    assert_only_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~$past(thread_en_i)) == '0);
    assert_one_thread_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !two |=> $countones(grant_o) <= 1);
    assert_two_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) <= 2);
    assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (thread_en_i == '0) |=> $stable(ptr_q));
    assert_distinct_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (f_vld && s_vld) |-> f_idx != s_idx);

    for (genvar t = 0; t < NT; t++) begin : g_chk
        assert_cnt_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
            grant_o[t] == (grant_cnt_o[t*GCW +: GCW] != '0));
    end
endmodule

// File: tb/sim_fetch_thread_sel.sv
`timescale 1ns/1ps
module sim_fetch_thread_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  pol = '0;
    logic [1:0]  spl = '0;
    logic [3:0]  en = '0;
    logic [3:0]  i_in = '0, i_out = '0, b_in = '0, b_res = '0, m_st = '0, m_dn = '0;
    logic [19:0] iqp = '0, fqp = '0;
    logic [3:0]  grant;
    logic [15:0] gcnt;

    int total = 0, bad = 0;
    bit done = 0;
    int mic[4], mbc[4], mmc[4];
    int mptr = 0;
    logic [3:0]  exp_g = '0;
    logic [15:0] exp_c = '0;
    string pend_tag = "R1";

    always #4 clk = ~clk;

    fetch_thread_sel u0 (
        .clk(clk), .rst_n(rst_n), .policy_i(pol), .split_i(spl), .thread_en_i(en),
        .inst_in_i(i_in), .inst_out_i(i_out), .br_in_i(b_in), .br_res_i(b_res),
        .miss_start_i(m_st), .miss_done_i(m_dn), .iq_pos_i(iqp), .fq_pos_i(fqp),
        .grant_o(grant), .grant_cnt_o(gcnt));

    function automatic int upd(int v, logic u, logic d);
        if (u && !d && v < 15) return v + 1;
        if (d && !u && v > 0) return v - 1;
        return v;
    endfunction

    // Reference ranking built from the requirements.
    task automatic predict();
        int met[4];
        int f = -1, s = -1, kf = 0, ks = 0, k, amt, last, q;
        bit two;
        for (int t = 0; t < 4; t++) begin
            case (pol)
                3'd1: met[t] = mic[t];
                3'd2: met[t] = mbc[t];
                3'd3: met[t] = mmc[t];
                3'd4: begin
                    q = (iqp[t*5 +: 5] < fqp[t*5 +: 5]) ? int'(iqp[t*5 +: 5]) : int'(fqp[t*5 +: 5]);
                    met[t] = 31 - q;
                end
                default: met[t] = 0;
            endcase
        end
        for (int t = 0; t < 4; t++) begin
            k = met[t] * 4 + ((t - mptr + 4) % 4);
            if (en[t] && (f < 0 || k < kf)) begin f = t; kf = k; end
        end
        two = (spl == 2'd1) || (spl == 2'd2);
        for (int t = 0; t < 4; t++) begin
            k = met[t] * 4 + ((t - mptr + 4) % 4);
            if (two && f >= 0 && en[t] && t != f && (s < 0 || k < ks)) begin s = t; ks = k; end
        end
        amt = (spl == 2'd1) ? 4 : 8;
        exp_g = '0;
        exp_c = '0;
        if (f >= 0) begin exp_g[f] = 1'b1; exp_c[f*4 +: 4] = 4'(amt); end
        if (s >= 0) begin exp_g[s] = 1'b1; exp_c[s*4 +: 4] = 4'(amt); end
        last = (s >= 0) ? s : f;
        if (f >= 0) mptr = (last + 1) % 4;
    endtask

    // One cycle: check the registered outputs, predict the next ones, step the model.
    task automatic step(string tag);
        total++;
        if (grant !== exp_g || gcnt !== exp_c) begin
            bad++;
            $display("FAIL %s actual grant=%b cnt=%h expected grant=%b cnt=%h",
                     pend_tag, grant, gcnt, exp_g, exp_c);
        end
        predict();
        for (int t = 0; t < 4; t++) begin
            mic[t] = upd(mic[t], i_in[t], i_out[t]);
            mbc[t] = upd(mbc[t], b_in[t], b_res[t]);
            mmc[t] = upd(mmc[t], m_st[t], m_dn[t]);
        end
        pend_tag = tag;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        i_in = '0; i_out = '0; b_in = '0; b_res = '0; m_st = '0; m_dn = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int bias;
        void'($urandom(32'h1dc0_4e21));
        for (int t = 0; t < 4; t++) begin mic[t] = 0; mbc[t] = 0; mmc[t] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state, then equal metrics resolved by pointer order.
        pol = 3'd1; spl = 2'd0; en = 4'hF;
        step("R12");
        repeat (5) step("R12");
        // Rotation with two-thread shapes.
        pol = 3'd0; spl = 2'd1;
        repeat (4) step("R4/R5");
        spl = 2'd2;
        repeat (3) step("R4/R10");
        // No one eligible, then sparse eligibility.
        en = 4'h0;
        repeat (3) step("R11/R5");
        en = 4'b0101; spl = 2'd1;
        repeat (3) step("R11/R10");
        en = 4'b1000; spl = 2'd2;
        repeat (2) step("R11");
        // Saturation: thread 0 pumped to 20, thread 1 to 15 then down one.
        pol = 3'd1; spl = 2'd0; en = 4'b0011;
        i_in = 4'b0011;
        repeat (15) step("R3");
        i_in = 4'b0001;
        repeat (5) step("R3");
        i_in = 4'b0000; i_out = 4'b0010;
        step("R3");
        quiet();
        repeat (3) step("R3/R6");
        // Floor: draining an empty counter, then one increment elsewhere.
        pol = 3'd2; en = 4'b1100; b_res = 4'b0100;
        repeat (4) step("R3");
        b_res = '0; b_in = 4'b1000;
        step("R3");
        quiet();
        repeat (2) step("R3/R7");
        // Queue position ranking.
        pol = 3'd4; en = 4'hF; spl = 2'd1;
        iqp = {5'd20, 5'd3, 5'd31, 5'd9}; fqp = {5'd25, 5'd31, 5'd2, 5'd31};
        repeat (3) step("R9");
        // Net-zero events on the miss counters.
        pol = 3'd3; m_st = 4'hF; m_dn = 4'b0101;
        repeat (3) step("R3/R8");
        quiet();

        // Random traffic with alternating up and down bias.
        for (int n = 0; n < 6000; n++) begin
            bias = ((n / 150) % 2 == 0) ? 75 : 15;
            pol = 3'($urandom % 8);
            spl = 2'($urandom % 4);
            en  = ($urandom % 4 == 0) ? 4'($urandom % 16) : 4'hF;
            for (int t = 0; t < 4; t++) begin
                i_in[t]  = ($urandom % 100) < bias;
                i_out[t] = ($urandom % 100) < (90 - bias);
                b_in[t]  = ($urandom % 100) < bias;
                b_res[t] = ($urandom % 100) < (90 - bias);
                m_st[t]  = ($urandom % 100) < bias;
                m_dn[t]  = ($urandom % 100) < (90 - bias);
            end
            iqp = 20'($urandom);
            fqp = 20'($urandom);
            case (pol)
                3'd1: step("R2/R6");
                3'd2: step("R2/R7");
                3'd3: step("R2/R8");
                3'd4: step("R2/R9");
                default: step("R4/R5");
            endcase
        end
        quiet();
        step("R10");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule